// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt events from up to sixteen sources into a pending-flag register. It gates each source according to its class and picks the single most urgent request. It then reports the word address of that request's slot in a vector table at the top of the address space. There are three classes. The topmost source is the reset class and is always honoured. A parameterized group of non-maskable sources each answer only to their own enable bit. All remaining sources are maskable and need their own enable bit and the global enable.

A sequencer models how the processor takes an interrupt. It accepts a new request only at an instruction boundary, which a completion strobe marks. It then runs a fixed-length entry phase, waits in service until a return strobe arrives, and runs a fixed-length return phase. The sequencer owns the global enable. Taking any interrupt clears it, and the return phase puts back the value it had before entry.

An external pin event can be routed either to the reset class or to one non-maskable source. A mode input makes that choice. The enable register lives in the block. A reset-class interrupt wipes that register and the global enable, in the same way a real reset does.

Top module: `prio_vec_intc`

## Requirements
- R1: The vector address of source i is 0xFFE0 + 2*i, so the reset source 15 maps to 0xFFFE and source 0 maps to 0xFFE0. `vec_addr` holds the slot of the most recently accepted request.
- R2: If several gated requests are pending together, the highest index is accepted. The others keep their pending bits and are accepted later, in descending index order.
- R3: A pending reset-class request (index 15) is accepted in the next cycle. This happens whatever the enables, the global enable, `instr_done` or the sequencer state. Its acceptance clears the enable register and the global enable.
- R4: A non-maskable source (indices 12, 13 and 14) is accepted when its own enable bit is set, whatever the global enable. While its enable bit is clear it stays pending and is never accepted.
- R5: A maskable source (indices 0 to 11) is accepted only when its enable bit and the global enable are both set. Otherwise it stays pending.
- R6: An external pin event sets the pending bit of source 15 when `xpin_nmi_mode` is 0, and of source 14 when it is 1.
- R7: A request other than reset is accepted only on a clock edge where the sequencer is idle and `instr_done` is high.
- R8: Acceptance starts an entry phase in which `entry_o` is high for exactly 6 cycles, after which `in_isr_o` goes high. From the first entry cycle onward the global enable reads 0.
- R9: In the first entry cycle `ack_o` shows the accepted source as a one-hot pulse of one cycle, and that source's pending bit already reads 0.
- R10: `reti` while in service starts a return phase in which `busy_o` stays high for 5 cycles. After it the block is idle and the global enable is back to its value before entry (0 after a reset-class entry). `reti` in any other state has no effect.
- R11: After `rst_n` the block is idle, and the pending bits, enable bits and global enable are 0. `vec_addr` reads 0xFFFE. With the enables at their reset value, no maskable request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_evt | input | 16 | One-cycle event pulses that set pending bits |
| xpin_evt | input | 1 | One-cycle event from the external pin |
| xpin_nmi_mode | input | 1 | 0: pin raises reset class; 1: pin raises source 14 |
| ie_we | input | 1 | Write strobe for the enable register |
| ie_wdata | input | 16 | New enable register value |
| gie_we | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | New global enable value |
| instr_done | input | 1 | Current instruction completes this cycle |
| reti | input | 1 | Return-from-interrupt strobe |
| vec_addr | output | 16 | Vector slot address of the accepted request |
| ack_o | output | 16 | One-hot acknowledge in the first entry cycle |
| entry_o | output | 1 | Entry phase in progress |
| busy_o | output | 1 | Sequencer not idle |
| in_isr_o | output | 1 | Service routine running |
| gie_o | output | 1 | Current global enable |
| pend_o | output | 16 | Pending flags |
| ie_o | output | 16 | Enable register |

## Verification
The assertions assume that `irq_evt` and `xpin_evt` are single-cycle pulses. They also assume that `instr_done` and `reti` change only between clock edges, and that the non-maskable mask never includes the top index. The stimulus drives every input on the falling edge and raises each event for exactly one cycle. It holds `instr_done` high only when it means a request to be taken, and raises `reti` only at the points the checks expect. That keeps the acceptance cycle and both phase lengths deterministic.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int unsigned VEC_W = 16;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ENTRY, SEQ_SERVE, SEQ_RETURN} seq_state_e;
  typedef enum logic [1:0] {CLS_MASKABLE, CLS_NONMASK, CLS_RESET} src_class_e;

  // slot address of a source index: one 2-byte word per source above the base
  function automatic logic [VEC_W-1:0] slot_addr(input logic [VEC_W-1:0] base,
                                                 input int unsigned idx);
    return base + VEC_W'(idx * 2);
  endfunction

  // class of a source: top index is reset, mask bits mark non-maskable
  function automatic src_class_e class_of(input int unsigned idx,
                                          input int unsigned n_src,
                                          input logic [31:0] nmi_mask);
    if (idx == n_src - 1) return CLS_RESET;
    if (nmi_mask[idx[4:0]]) return CLS_NONMASK;
    return CLS_MASKABLE;
  endfunction
endpackage

// File: rtl/intc_flags.sv
module intc_flags #(
  parameter int unsigned N_SRC       = 16,
  parameter int unsigned PIN_NMI_IDX = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_evt,
  input  logic             xpin_evt,
  input  logic             xpin_nmi_mode,
  input  logic             ie_we,
  input  logic [N_SRC-1:0] ie_wdata,
  input  logic [N_SRC-1:0] svc_clr,
  input  logic             rst_taken,
  output logic [N_SRC-1:0] pend_q,
  output logic [N_SRC-1:0] ie_q
);
  localparam int unsigned RST_IDX = N_SRC - 1;

  logic [N_SRC-1:0] pin_set;
  logic [N_SRC-1:0] set_vec;
  logic [N_SRC-1:0] drop_vec;

  always_comb begin
    pin_set = '0;
    if (xpin_evt) begin
      if (xpin_nmi_mode) pin_set[PIN_NMI_IDX] = 1'b1;
      else               pin_set[RST_IDX]     = 1'b1;
    end
  end

  assign set_vec  = irq_evt | pin_set;
  assign drop_vec = svc_clr & ~set_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      ie_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~svc_clr) | set_vec;
      if (rst_taken)  ie_q <= '0;
      else if (ie_we) ie_q <= ie_wdata;
    end
  end

  AST_PIN_TO_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    (xpin_evt && xpin_nmi_mode) |=> pend_q[PIN_NMI_IDX]); // R6
  AST_PIN_TO_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (xpin_evt && !xpin_nmi_mode) |=> pend_q[RST_IDX]); // R6
  AST_IE_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_taken |=> (ie_q == '0)); // R3
  AST_SERVED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (|drop_vec) |=> ((pend_q & $past(drop_vec)) == '0)); // R9
endmodule

// File: rtl/intc_arb.sv
module intc_arb
  import prio_intc_pkg::*;
#(
  parameter int unsigned       N_SRC    = 16,
  parameter logic [N_SRC-1:0]  NMI_MASK = 16'h7000,
  localparam int unsigned      IDX_W    = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] ie,
  input  logic             gie,
  output logic [N_SRC-1:0] grant,
  output logic [IDX_W-1:0] grant_idx,
  output logic             any_req,
  output logic             rst_req
);
  logic [N_SRC-1:0] req;
  logic [N_SRC-1:0] is_mask;
  logic [N_SRC-1:0] is_nmi;
  logic             found;

  for (genvar g = 0; g < N_SRC; g++) begin : g_gate
    localparam src_class_e CLS = class_of(g, N_SRC, 32'(NMI_MASK));
    if (CLS == CLS_RESET) begin : g_rst
      assign req[g]     = pend[g];
      assign is_mask[g] = 1'b0;
      assign is_nmi[g]  = 1'b0;
    end else if (CLS == CLS_NONMASK) begin : g_nmi
      assign req[g]     = pend[g] & ie[g];
      assign is_mask[g] = 1'b0;
      assign is_nmi[g]  = 1'b1;
    end else begin : g_msk
      assign req[g]     = pend[g] & ie[g] & gie;
      assign is_mask[g] = 1'b1;
      assign is_nmi[g]  = 1'b0;
    end
  end

  always_comb begin
    found     = 1'b0;
    grant_idx = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (!found && req[k]) begin
        found     = 1'b1;
        grant_idx = IDX_W'(k);
      end
    end
  end

  assign grant   = found ? (N_SRC'(1) << grant_idx) : '0;
  assign any_req = found;
  assign rst_req = grant[N_SRC-1];

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pend[N_SRC-1] |-> grant[N_SRC-1]); // R3
  AST_NMI_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(grant & is_nmi)) |-> (|(grant & ie))); // R4
  AST_MASKABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(grant & is_mask)) |-> (gie && (|(grant & ie)))); // R5
endmodule

// File: rtl/intc_seq.sv
module intc_seq
  import prio_intc_pkg::*;
#(
  parameter int unsigned       N_SRC     = 16,
  parameter logic [VEC_W-1:0]  VEC_BASE  = 16'hFFE0,
  parameter int unsigned       ENTRY_CYC = 6,
  parameter int unsigned       RET_CYC   = 5,
  localparam int unsigned      IDX_W     = $clog2(N_SRC),
  localparam int unsigned      MAX_CYC   = (ENTRY_CYC > RET_CYC) ? ENTRY_CYC : RET_CYC,
  localparam int unsigned      CNT_W     = $clog2(MAX_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_req,
  input  logic             rst_req,
  input  logic [N_SRC-1:0] grant,
  input  logic [IDX_W-1:0] grant_idx,
  input  logic             instr_done,
  input  logic             reti,
  input  logic             gie_we,
  input  logic             gie_wdata,
  output logic             take,
  output logic             rst_take,
  output logic [N_SRC-1:0] ack_q,
  output logic [VEC_W-1:0] vec_q,
  output logic             gie_q,
  output logic             entry,
  output logic             busy,
  output logic             serve
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             gie_saved_q;
  logic             entry_last;
  logic             ret_last;
  logic [CNT_W-1:0] ent_run_q;

  assign take       = rst_req | ((state_q == SEQ_IDLE) & instr_done & any_req);
  assign rst_take   = rst_req;
  assign entry_last = (state_q == SEQ_ENTRY)  && (cnt_q == CNT_W'(ENTRY_CYC - 1));
  assign ret_last   = (state_q == SEQ_RETURN) && (cnt_q == CNT_W'(RET_CYC - 1));
  assign entry      = (state_q == SEQ_ENTRY);
  assign busy       = (state_q != SEQ_IDLE);
  assign serve      = (state_q == SEQ_SERVE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= SEQ_IDLE;
      cnt_q       <= '0;
      gie_q       <= 1'b0;
      gie_saved_q <= 1'b0;
      ack_q       <= '0;
      vec_q       <= slot_addr(VEC_BASE, N_SRC - 1);
    end else begin
      ack_q <= '0;
      if (take) begin
        state_q     <= SEQ_ENTRY;
        cnt_q       <= '0;
        ack_q       <= grant;
        vec_q       <= slot_addr(VEC_BASE, 32'(grant_idx));
        gie_q       <= 1'b0;
        gie_saved_q <= rst_req ? 1'b0 : gie_q;
      end else begin
        case (state_q)
          SEQ_ENTRY: begin
            if (entry_last) begin
              state_q <= SEQ_SERVE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          SEQ_SERVE: begin
            if (reti) begin
              state_q <= SEQ_RETURN;
              cnt_q   <= '0;
            end
          end
          SEQ_RETURN: begin
            if (ret_last) begin
              state_q <= SEQ_IDLE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: begin
            cnt_q <= '0;
          end
        endcase
        if (ret_last)    gie_q <= gie_saved_q;
        else if (gie_we) gie_q <= gie_wdata;
      end
    end
  end

  // independent run counter of consecutive entry cycles for the bound check
  always_ff @(posedge clk) begin
    if (!rst_n)              ent_run_q <= '0;
    else if (entry && !take) ent_run_q <= ent_run_q + 1'b1;
    else                     ent_run_q <= '0;
  end

  AST_GIE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie_q); // R8
  AST_ENTRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    entry |-> (ent_run_q < CNT_W'(ENTRY_CYC))); // R8
  AST_DONE_GATES_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(entry) && !ack_q[N_SRC-1]) |-> $past(instr_done)); // R7
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_q)); // R9
  AST_ACK_IN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_q) |-> entry); // R9
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !take) |=> !busy); // R10
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import prio_intc_pkg::*;
#(
  parameter int unsigned       N_SRC       = 16,
  parameter logic [VEC_W-1:0]  VEC_BASE    = 16'hFFE0,
  parameter logic [N_SRC-1:0]  NMI_MASK    = 16'h7000,
  parameter int unsigned       PIN_NMI_IDX = N_SRC - 2,
  parameter int unsigned       ENTRY_CYC   = 6,
  parameter int unsigned       RET_CYC     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_evt,
  input  logic             xpin_evt,
  input  logic             xpin_nmi_mode,
  input  logic             ie_we,
  input  logic [N_SRC-1:0] ie_wdata,
  input  logic             gie_we,
  input  logic             gie_wdata,
  input  logic             instr_done,
  input  logic             reti,
  output logic [VEC_W-1:0] vec_addr,
  output logic [N_SRC-1:0] ack_o,
  output logic             entry_o,
  output logic             busy_o,
  output logic             in_isr_o,
  output logic             gie_o,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] ie_o
);
  localparam int unsigned IDX_W = $clog2(N_SRC);

  logic [N_SRC-1:0] pend_w;
  logic [N_SRC-1:0] ie_w;
  logic [N_SRC-1:0] grant_w;
  logic [IDX_W-1:0] grant_idx_w;
  logic             any_req_w;
  logic             rst_req_w;
  logic             take_w;
  logic             rst_take_w;
  logic             gie_w;
  logic [N_SRC-1:0] svc_clr_w;

  assign svc_clr_w = take_w ? grant_w : '0;

  intc_flags #(.N_SRC(N_SRC), .PIN_NMI_IDX(PIN_NMI_IDX)) u_flags (
    .clk(clk), .rst_n(rst_n), .irq_evt(irq_evt), .xpin_evt(xpin_evt),
    .xpin_nmi_mode(xpin_nmi_mode), .ie_we(ie_we), .ie_wdata(ie_wdata),
    .svc_clr(svc_clr_w), .rst_taken(rst_take_w), .pend_q(pend_w), .ie_q(ie_w)
  );

  intc_arb #(.N_SRC(N_SRC), .NMI_MASK(NMI_MASK)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend_w), .ie(ie_w), .gie(gie_w),
    .grant(grant_w), .grant_idx(grant_idx_w), .any_req(any_req_w), .rst_req(rst_req_w)
  );

  intc_seq #(.N_SRC(N_SRC), .VEC_BASE(VEC_BASE), .ENTRY_CYC(ENTRY_CYC), .RET_CYC(RET_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .any_req(any_req_w), .rst_req(rst_req_w),
    .grant(grant_w), .grant_idx(grant_idx_w), .instr_done(instr_done), .reti(reti),
    .gie_we(gie_we), .gie_wdata(gie_wdata), .take(take_w), .rst_take(rst_take_w),
    .ack_q(ack_o), .vec_q(vec_addr), .gie_q(gie_w), .entry(entry_o),
    .busy(busy_o), .serve(in_isr_o)
  );

  assign gie_o  = gie_w;
  assign pend_o = pend_w;
  assign ie_o   = ie_w;
endmodule

// File: tb/prio_vec_intc_tb_top.sv
`timescale 1ns/1ps
module prio_vec_intc_tb_top;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_evt = '0;
  logic          xpin_evt = 1'b0;
  logic          xpin_nmi_mode = 1'b0;
  logic          ie_we = 1'b0;
  logic [N-1:0]  ie_wdata = '0;
  logic          gie_we = 1'b0;
  logic          gie_wdata = 1'b0;
  logic          instr_done = 1'b0;
  logic          reti = 1'b0;
  logic [15:0]   vec_addr;
  logic [N-1:0]  ack_o;
  logic          entry_o, busy_o, in_isr_o, gie_o;
  logic [N-1:0]  pend_o, ie_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  prio_vec_intc dut_i (
    .clk(clk), .rst_n(rst_n), .irq_evt(irq_evt), .xpin_evt(xpin_evt),
    .xpin_nmi_mode(xpin_nmi_mode), .ie_we(ie_we), .ie_wdata(ie_wdata),
    .gie_we(gie_we), .gie_wdata(gie_wdata), .instr_done(instr_done), .reti(reti),
    .vec_addr(vec_addr), .ack_o(ack_o), .entry_o(entry_o), .busy_o(busy_o),
    .in_isr_o(in_isr_o), .gie_o(gie_o), .pend_o(pend_o), .ie_o(ie_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // counted down from the top slot
  function automatic logic [15:0] exp_vec(input int i);
    return 16'hFFFE - 16'((15 - i) * 2);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic [N-1:0] v);
    irq_evt = v; tick(); irq_evt = '0;
  endtask

  task automatic write_ie(input logic [N-1:0] v);
    ie_we = 1'b1; ie_wdata = v; tick(); ie_we = 1'b0;
  endtask

  task automatic write_gie(input bit v);
    gie_we = 1'b1; gie_wdata = v; tick(); gie_we = 1'b0;
  endtask

  task automatic start_entry(input int i);
    instr_done = 1'b1; tick(); instr_done = 1'b0;
    chk(entry_o === 1'b1, "R8 entry starts", 32'(entry_o), 1);
    chk(ack_o === (N'(1) << i), "R9 one-hot ack", 32'(ack_o), 32'(N'(1) << i));
    chk(vec_addr === exp_vec(i), "R1 vector slot", 32'(vec_addr), 32'(exp_vec(i)));
    chk(gie_o === 1'b0, "R8 gie cleared on entry", 32'(gie_o), 0);
    chk(pend_o[i] === 1'b0, "R9 pending dropped", 32'(pend_o[i]), 0);
  endtask

  task automatic finish_service(input bit gie_prev);
    for (int k = 1; k < 6; k++) begin
      tick();
      chk(entry_o === 1'b1 && ack_o === '0, "R8 entry held", {ack_o, entry_o}, 1);
    end
    tick();
    chk(entry_o === 1'b0 && in_isr_o === 1'b1, "R8 entry six cycles", {in_isr_o, entry_o}, 2);
    reti = 1'b1; tick(); reti = 1'b0;
    chk(busy_o === 1'b1 && in_isr_o === 1'b0, "R10 return starts", {in_isr_o, busy_o}, 1);
    for (int k = 1; k < 5; k++) begin
      tick();
      chk(busy_o === 1'b1, "R10 return held", 32'(busy_o), 1);
    end
    tick();
    chk(busy_o === 1'b0, "R10 return five cycles", 32'(busy_o), 0);
    chk(gie_o === gie_prev, "R10 gie restored", 32'(gie_o), 32'(gie_prev));
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(busy_o === 1'b0 && gie_o === 1'b0, "R11 idle with gie off", {gie_o, busy_o}, 0);
    chk(pend_o === '0 && ie_o === '0, "R11 flags and enables clear", {pend_o, ie_o}, 0);
    chk(vec_addr === 16'hFFFE, "R11 vector at reset", 32'(vec_addr), 32'hFFFE);

    // R11 maskable off by default even with gie set
    write_gie(1'b1);
    pulse(N'(1));
    instr_done = 1'b1; tick(); tick(); instr_done = 1'b0;
    chk(busy_o === 1'b0, "R11 maskable off after reset", 32'(busy_o), 0);
    write_ie('1);
    start_entry(0); finish_service(1'b1);

    // R1 sweep of every non-reset source
    for (int i = 1; i < 15; i++) begin
      pulse(N'(1) << i);
      start_entry(i); finish_service(1'b1);
    end

    // R7 no entry without instruction completion
    pulse(N'(1) << 5);
    repeat (4) tick();
    chk(busy_o === 1'b0 && pend_o[5] === 1'b1, "R7 waits for instr_done", {pend_o[5], busy_o}, 2);
    start_entry(5); finish_service(1'b1);

    // R10 reti while idle has no effect
    reti = 1'b1; tick(); reti = 1'b0; tick();
    chk(busy_o === 1'b0 && gie_o === 1'b1, "R10 reti ignored in idle", {gie_o, busy_o}, 2);

    // R4 / R5 gating sweep
    for (int i = 0; i < 15; i++) begin
      for (int c = 0; c < 4; c++) begin
        bit ieb = c[0];
        bit g   = c[1];
        bit exp_take = (i >= 12) ? ieb : (ieb & g);
        write_ie(ieb ? (N'(1) << i) : '0);
        write_gie(g);
        pulse(N'(1) << i);
        instr_done = 1'b1; tick(); instr_done = 1'b0;
        if (i >= 12) chk(entry_o === exp_take, "R4 nmi gating", 32'(entry_o), 32'(exp_take));
        else         chk(entry_o === exp_take, "R5 maskable gating", 32'(entry_o), 32'(exp_take));
        if (exp_take) begin
          finish_service(g);
        end else begin
          chk(pend_o[i] === 1'b1, "R5 rejected stays pending", 32'(pend_o[i]), 1);
          write_ie('1); write_gie(1'b1);
          start_entry(i); finish_service(1'b1);
        end
      end
    end

    // R3 / R2 all sources at once: reset first, then descending
    pulse('1);
    start_entry(15);
    chk(ie_o === '0, "R3 reset clears enables", 32'(ie_o), 0);
    finish_service(1'b0);
    write_ie('1); write_gie(1'b1);
    for (int k = 14; k >= 0; k--) begin
      chk(pend_o[k] === 1'b1, "R2 lower request still pending", 32'(pend_o[k]), 1);
      start_entry(k);
      if (k > 0) chk(pend_o[k-1] === 1'b1, "R2 loser kept", 32'(pend_o[k-1]), 1);
      finish_service(1'b1);
    end

    // R2 selected pairs
    for (int p = 0; p < 5; p++) begin
      int lo = (p == 0) ? 0 : (p == 1) ? 3 : (p == 2) ? 2 : (p == 3) ? 12 : 7;
      int hi = (p == 0) ? 1 : (p == 1) ? 11 : (p == 2) ? 13 : (p == 3) ? 14 : 9;
      pulse((N'(1) << lo) | (N'(1) << hi));
      start_entry(hi);
      chk(pend_o[lo] === 1'b1, "R2 pair loser waits", 32'(pend_o[lo]), 1);
      finish_service(1'b1);
      start_entry(lo); finish_service(1'b1);
    end

    // R3 reset preempts a running service routine
    pulse(N'(1) << 3);
    start_entry(3);
    repeat (6) tick();
    chk(in_isr_o === 1'b1, "R3 in service before preempt", 32'(in_isr_o), 1);
    pulse(N'(1) << 15);
    start_entry(15);
    chk(ie_o === '0, "R3 preempt clears enables", 32'(ie_o), 0);
    finish_service(1'b0);

    // R6 external pin routing
    write_ie('1); write_gie(1'b1);
    xpin_nmi_mode = 1'b0;
    xpin_evt = 1'b1; tick(); xpin_evt = 1'b0;
    chk(pend_o[15] === 1'b1 && pend_o[14] === 1'b0, "R6 pin as reset", {pend_o[15], pend_o[14]}, 2);
    start_entry(15); finish_service(1'b0);
    write_ie('1); write_gie(1'b1);
    xpin_nmi_mode = 1'b1;
    xpin_evt = 1'b1; tick(); xpin_evt = 1'b0;
    chk(pend_o[14] === 1'b1 && pend_o[15] === 1'b0, "R6 pin as nmi", {pend_o[15], pend_o[14]}, 1);
    start_entry(14); finish_service(1'b1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule